// File: doc/BRIEF.md
# Pulse repetition and reload timing generator

This block sequences the transmit periods of a coded-pulse radar front end. It receives a slow reference clock from another clock domain and brings it into the fast shift-clock domain through a flop synchroniser. It divides the reference by a parameterised ratio (eight by default) to form a square repetition signal. While that signal is high, the block issues a shift enable to a downstream pair of parallel-load shift registers. While it is low, the block issues a reload strobe that tells those registers to take their next pattern.

The reload strobe starts a programmable number of fast cycles after the repetition signal drops, the guard count, and lasts a programmable number of fast cycles, the load count. Both counts are sampled once per period. A pair that would not fit in the low phase is refused, and the pair accepted last stays in use. The shift enable either fires on every fast cycle or on every second one. This models the choice between the two fast-clock rates. The rate is sampled at the start of each high window. A one-cycle start pulse marks the first high cycle of every window.

Top module: `prt_gen`

## Requirements
- R1: While reset is asserted, `rep_o`, `start_o`, `reload_o` and `shift_en_o` are all 0.
- R2: With the default DIV=8, `rep_o` stays high for four reference periods and then low for four reference periods. With a reference period of 8 fast cycles, each phase lasts 32 cycles.
- R3: `start_o` is 1 for exactly one cycle per window: the first cycle in which `rep_o` is 1.
- R4: `shift_en_o` is 1 only in cycles where `rep_o` is 1.
- R5: When `rate_half_i` was 0 at the start of a window, `shift_en_o` is 1 on every cycle of that high window.
- R6: When `rate_half_i` was 1 at the start of a window, `shift_en_o` is 1 on alternate cycles. The first of these is the start cycle, which gives 16 enables in a 32-cycle window. The rate input is sampled only at the start of a window.
- R7: Index the low-phase cycles so that the first low cycle is cycle 0. Then `reload_o` first goes to 1 at cycle G, where G is the accepted guard count, and stays at 1 for W consecutive cycles, where W is the accepted load count. G=0 puts the strobe in cycle 0.
- R8: The guard and load counts are sampled on the cycle before `rep_o` falls. A pair is accepted only if W is at least 1 and G+W is no more than LOW_BUDGET (24 by default). A refused pair leaves the previously accepted pair in use. After reset the accepted pair is G=2, W=4.
- R9: `reload_o` and `rep_o` are never 1 in the same cycle; a strobe still running when the window opens is cut off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock from the slow domain, sampled as data |
| guard_cnt_i | input | CNT_W | Fast cycles from the repetition fall to the reload strobe |
| load_cnt_i | input | CNT_W | Length of the reload strobe in fast cycles |
| rate_half_i | input | 1 | 1 selects the half shift rate, 0 the full rate |
| rep_o | output | 1 | Repetition signal |
| start_o | output | 1 | One-cycle marker of each high window's first cycle |
| reload_o | output | 1 | Reload strobe for the pattern registers |
| shift_en_o | output | 1 | Shift enable, active only inside the high window |

## Verification
The assertions check, on every cycle, four properties of single cycles. The reload strobe and the repetition signal are never high together. The shift enable appears only inside the high window. The start pulse coincides exactly with the rising repetition signal. Every start cycle also shifts.

The scenarios are needed for the properties that span a whole window. These cover the 32-cycle phase lengths and the exact number of shift enables at each rate. They also cover the guard offset and strobe length for each programmed pair, including a zero guard and a pair that exactly fills the budget. Finally, the scenarios show that a refused pair, such as a zero load or an oversize sum, leaves the earlier timing in force.

// File: rtl/prt_pkg.sv
package prt_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_GUARD = 2'd1,
        SEQ_LOAD  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/prt_ref_sync.sv
// Brings the reference clock into the fast domain and flags its rising edges.
module prt_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.last     = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/prt_rep_div.sv
// Divides the synchronised reference edges into the repetition square wave.
module prt_rep_div #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_rise_i,
    output logic rep_o,
    output logic start_o,
    output logic rise_nx_o,
    output logic fall_nx_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rep;
        logic          start;
    } div_t;

    div_t d_d, d_q;
    logic fall_nx;

    always_comb begin
        d_d       = d_q;
        d_d.start = 1'b0;
        fall_nx   = 1'b0;
        if (ref_rise_i) begin
            if (d_q.cnt == CW'(HALF - 1)) begin
                d_d.cnt   = '0;
                d_d.rep   = ~d_q.rep;
                d_d.start = ~d_q.rep;
                fall_nx   = d_q.rep;
            end else begin
                d_d.cnt = d_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign rep_o     = d_q.rep;
    assign start_o   = d_q.start;
    assign rise_nx_o = d_d.start;
    assign fall_nx_o = fall_nx;
endmodule

// File: rtl/prt_reload_seq.sv
// Guard delay then fixed-width reload strobe inside the low phase.
module prt_reload_seq
    import prt_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int LOW_BUDGET  = 24,
    parameter int RESET_GUARD = 2,
    parameter int RESET_LOAD  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_nx_i,
    input  logic             rise_nx_i,
    input  logic [CNT_W-1:0] guard_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             reload_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] guard;
        logic [CNT_W-1:0] load;
    } seq_t;

    seq_t r_d, r_q;
    logic [CNT_W:0]   sum;
    logic             cfg_fits;
    logic [CNT_W-1:0] g_use, w_use;

    always_comb begin
        sum      = {1'b0, guard_i} + {1'b0, load_i};
        cfg_fits = (load_i != '0) && (sum <= (CNT_W+1)'(LOW_BUDGET));
        g_use    = cfg_fits ? guard_i : r_q.guard;
        w_use    = cfg_fits ? load_i  : r_q.load;

        r_d = r_q;
        unique case (r_q.state)
            SEQ_GUARD: begin
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.state = SEQ_LOAD;
                    r_d.cnt   = r_q.load - CNT_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            SEQ_LOAD: begin
                if (r_q.cnt == '0) begin
                    r_d.state = SEQ_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase

        if (fall_nx_i) begin
            r_d.guard = g_use;
            r_d.load  = w_use;
            if (g_use == '0) begin
                r_d.state = SEQ_LOAD;
                r_d.cnt   = w_use - CNT_W'(1);
            end else begin
                r_d.state = SEQ_GUARD;
                r_d.cnt   = g_use;
            end
        end

        if (rise_nx_i) begin
            r_d.state = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= SEQ_IDLE;
            r_q.cnt   <= '0;
            r_q.guard <= CNT_W'(RESET_GUARD);
            r_q.load  <= CNT_W'(RESET_LOAD);
        end else begin
            r_q <= r_d;
        end
    end

    assign reload_o = (r_q.state == SEQ_LOAD);
endmodule

// File: rtl/prt_shift_gate.sv
// Gates the shift enable with the repetition window at full or half rate.
module prt_shift_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_nx_i,
    input  logic rate_half_i,
    input  logic rep_i,
    output logic shift_en_o
);
    typedef struct packed {
        logic phase;
        logic half;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (rise_nx_i) begin
            g_d.phase = 1'b0;
            g_d.half  = rate_half_i;
        end else begin
            g_d.phase = ~g_q.phase;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign shift_en_o = rep_i & (~g_q.half | ~g_q.phase);
endmodule

// File: rtl/prt_gen.sv
module prt_gen #(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6,
    parameter int LOW_BUDGET  = 24,
    parameter int RESET_GUARD = 2,
    parameter int RESET_LOAD  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_clk_i,
    input  logic [CNT_W-1:0] guard_cnt_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             rate_half_i,
    output logic             rep_o,
    output logic             start_o,
    output logic             reload_o,
    output logic             shift_en_o
);
    logic ref_rise, rise_nx, fall_nx, rep;

    prt_ref_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_clk_i), .rise_o(ref_rise)
    );

    prt_rep_div #(.DIV(DIV)) div_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ref_rise_i(ref_rise),
        .rep_o(rep), .start_o(start_o), .rise_nx_o(rise_nx), .fall_nx_o(fall_nx)
    );

    prt_reload_seq #(
        .CNT_W(CNT_W), .LOW_BUDGET(LOW_BUDGET),
        .RESET_GUARD(RESET_GUARD), .RESET_LOAD(RESET_LOAD)
    ) seq_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .fall_nx_i(fall_nx), .rise_nx_i(rise_nx),
        .guard_i(guard_cnt_i), .load_i(load_cnt_i), .reload_o(reload_o)
    );

    prt_shift_gate gate_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .rise_nx_i(rise_nx),
        .rate_half_i(rate_half_i), .rep_i(rep), .shift_en_o(shift_en_o)
    );

    assign rep_o = rep;
endmodule

// File: rtl/prt_gen_checks.sv
module prt_gen_checks (
    input logic clk_i,
    input logic rst_ni,
    input logic rep_o,
    input logic start_o,
    input logic reload_o,
    input logic shift_en_o
);
    // R9: strobe and window exclusive
    p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rep_o && reload_o));

    // R4: shift only inside the window
    p_shift_in_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en_o |-> rep_o);

    // R3: start marks exactly the rising window
    p_start_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o == $rose(rep_o));

    // R6: the first cycle of every window shifts at either rate
    p_first_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> shift_en_o);
endmodule

bind prt_gen prt_gen_checks chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rep_o(rep_o), .start_o(start_o),
    .reload_o(reload_o), .shift_en_o(shift_en_o)
);

// File: tb/prt_gen_tb_top.sv
module prt_gen_tb_top;
    localparam int CNT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic [CNT_W-1:0] guard_cnt = 6'd3;
    logic [CNT_W-1:0] load_cnt  = 6'd5;
    logic rate_half = 1'b0;
    logic rep, start, reload, shift_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    typedef struct {
        int g;
        int w;
        bit half;
    } exp_t;
    exp_t sb_q[$];

    prt_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
        .guard_cnt_i(guard_cnt), .load_cnt_i(load_cnt), .rate_half_i(rate_half),
        .rep_o(rep), .start_o(start), .reload_o(reload), .shift_en_o(shift_en)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (4) @(negedge clk);
            ref_clk = ~ref_clk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver: program one pair per window and push the expected accepted values
    int acc_g = 2;
    int acc_w = 4;
    task automatic drive(input int g, input int w, input bit half);
        exp_t e;
        do @(negedge clk); while (!start);
        repeat (6) @(negedge clk);
        guard_cnt = CNT_W'(g);
        load_cnt  = CNT_W'(w);
        rate_half = half;
        if (w != 0 && g + w <= 24) begin
            acc_g = g;
            acc_w = w;
        end
        e.g = acc_g; e.w = acc_w; e.half = half;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(rep == 0 && start == 0 && reload == 0 && shift_en == 0, "R1 reset outputs",
              {rep, start, reload, shift_en}, 0);
        rst_n = 1'b1;
        drive(3, 5, 1'b0);    // R7 basic pair
        drive(0, 1, 1'b1);    // R7 zero guard, single-cycle strobe; R6 half rate
        drive(10, 14, 1'b0);  // R8 sum exactly at budget
        drive(20, 10, 1'b1);  // R8 oversize sum refused
        drive(4, 0, 1'b0);    // R8 zero load refused
        drive(23, 1, 1'b1);   // R7 late strobe
        drive(1, 8, 1'b0);
        wait (done);
        report();
    end

    // monitor: measure each window and pop the expected item at every fall
    initial begin
        bit prev_rep = 0, seen_rise = 0, have_item = 0, cur_half = 0;
        int idx = 0, hi_len = 0, shifts = 0, rl_first = -1, rl_w = 0, cur_g = 0, cur_w = 0;
        exp_t it;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            check(start == (rep && !prev_rep), "R3 start pulse", start, rep && !prev_rep);
            if (rep && reload) check(1'b0, "R9 overlap", reload, 0);
            if (shift_en && !rep) check(1'b0, "R4 shift outside window", shift_en, 0);
            if (rep && !prev_rep) begin
                if (have_item) begin
                    check(rl_first == cur_g, "R7/R8 reload offset", rl_first, cur_g);
                    check(rl_w == cur_w, "R7/R8 reload width", rl_w, cur_w);
                    check(idx == 32, "R2 low length", idx, 32);
                end
                seen_rise = 1; hi_len = 0; shifts = 0;
            end
            if (!rep && prev_rep) begin
                if (seen_rise) begin
                    check(hi_len == 32, "R2 high length", hi_len, 32);
                    if (cur_half) check(shifts == 16, "R6 half rate count", shifts, 16);
                    else          check(shifts == 32, "R5 full rate count", shifts, 32);
                end
                if (sb_q.size() != 0) begin
                    it = sb_q.pop_front();
                    cur_g = it.g; cur_w = it.w; cur_half = it.half; have_item = 1;
                end else begin
                    done = 1'b1;
                end
                idx = 0; rl_first = -1; rl_w = 0;
            end
            if (rep) begin
                hi_len++;
                if (shift_en) shifts++;
            end else begin
                if (reload) begin
                    if (rl_first < 0) rl_first = idx;
                    rl_w++;
                end
                idx++;
            end
            prev_rep = rep;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end
endmodule